// File: doc/BRIEF.md
# Multi-Operand Reducer with Two-Column Counters

This block adds a parameterized set of equal-width binary rows, such as the partial products of a multiplier built from 8x8 sub-multipliers, and delivers their exact total as one registered word. It does not form partial products. It only reduces rows that are already formed.

The rows pass through three compression levels. Each level splits its rows into groups of five. Inside a group, every pair of adjacent bit columns (2j, 2j+1) goes into one two-column counter. The counter takes five bits of the lower weight and five bits of the upper weight and returns a 4-bit count that lands on columns 2j through 2j+3. Counters on even pairs fill one output row and counters on odd pairs fill a second one, so each group of five rows becomes two rows.

After the third level exactly two rows remain. A carry-lookahead adder built from 4-bit lookahead groups adds them, and the sum is captured on the next rising clock edge. The block has no state machine: one reset-cleared output register holds all of its state. It accepts 1 to 25 input rows, which is the most that three levels can bring down to two.

Top module: `red554_top`

## Requirements
- R1: Each counter outputs the count of set bits in its five lower-weight inputs plus twice the count of set bits in its five upper-weight inputs (range 0 to 15). Output bits 0..3 of a counter fed from columns 2j and 2j+1 carry weights 2^(2j) through 2^(2j+3).
- R2: `o_sum` equals the arithmetic sum of all NUM_ROWS rows of `i_rows`, where row r occupies bits [r*ROW_W +: ROW_W]. The output width is OUT_W = ROW_W + clog2(NUM_ROWS), and no carry is lost.
- R3: `o_sum` shows the sum of the rows present at the previous rising clock edge, with a latency of one cycle and a new result every cycle.
- R4: While `rst_n` is low, `o_sum` is zero. Assertion of `rst_n` clears the output without waiting for a clock edge.
- R5: When every row is all ones, the result is NUM_ROWS * (2^ROW_W - 1).
- R6: When exactly one row is nonzero, its value appears unchanged on `o_sum`. Zero padding of empty counter inputs adds nothing.
- R7: Every compression level preserves the total of its rows modulo the internal width, and turns R rows into 2*ceil(R/5) rows.
- R8: The final lookahead adder returns the exact sum of the two remaining rows, including carries that ripple across every 4-bit group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| i_rows | input | NUM_ROWS*ROW_W | Packed rows to be summed, row r at bits [r*ROW_W +: ROW_W] |
| o_sum | output | OUT_W | Registered total of all rows |

## Verification
The only timed result is `o_sum`. It becomes due at the first rising edge after the rows are applied. The bench drives new rows right after a falling edge and compares the output at the next falling edge, which is half a period after the capturing edge. A queue holds the expected totals, so back-to-back random patterns are checked in the cycle they belong to. Reset is checked one time step after `rst_n` falls and again after a full clock period held low.

// File: rtl/red554_pkg.sv
package red554_pkg;

    // Rows left after one compression level: two rows per group of five.
    function automatic int rows_after(input int rows_in);
        return 2 * ((rows_in + 4) / 5);
    endfunction

endpackage

// File: rtl/red_ctr554.sv
// Two-column counter: five bits of weight 1 and five bits of weight 2,
// returned as a 4-bit count (a 10-in, 4-out lookup computed on the fly).
module red_ctr554 (
    input  logic [4:0] lo_i,
    input  logic [4:0] hi_i,
    output logic [3:0] sum_o
);

    always_comb begin
        sum_o = '0;
        for (int k = 0; k < 5; k++) begin
            sum_o = sum_o + {3'b000, lo_i[k]} + {2'b00, hi_i[k], 1'b0};
        end
    end

endmodule

// File: rtl/red_level.sv
// One compression level: groups of five rows become two rows each.
module red_level #(
    parameter int ROWS_IN  = 8,
    parameter int W        = 20,
    parameter int ROWS_OUT = red554_pkg::rows_after(ROWS_IN)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [ROWS_IN*W-1:0]   rows_i,
    output logic [ROWS_OUT*W-1:0]  rows_o
);

    localparam int GROUPS = (ROWS_IN + 4) / 5;
    localparam int PADR   = GROUPS * 5;
    localparam int PAIRS  = W / 2;

    logic [W-1:0] padded [PADR];
    logic [3:0]   csum   [GROUPS][PAIRS];
    logic [W-1:0] outr   [ROWS_OUT];

    for (genvar r = 0; r < PADR; r++) begin : g_pad
        if (r < ROWS_IN) begin : g_real
            assign padded[r] = rows_i[r*W +: W];
        end else begin : g_zero
            assign padded[r] = '0;
        end
    end

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        for (genvar j = 0; j < PAIRS; j++) begin : g_pair
            logic [4:0] lo_b;
            logic [4:0] hi_b;
            for (genvar r = 0; r < 5; r++) begin : g_tap
                assign lo_b[r] = padded[5*g + r][2*j];
                assign hi_b[r] = padded[5*g + r][2*j + 1];
            end
            red_ctr554 u_ctr (
                .lo_i  (lo_b),
                .hi_i  (hi_b),
                .sum_o (csum[g][j])
            );
        end
    end

    // Even pairs fill one row, odd pairs the other: their spans never overlap.
    always_comb begin
        for (int o = 0; o < ROWS_OUT; o++) begin
            outr[o] = '0;
        end
        for (int g = 0; g < GROUPS; g++) begin
            for (int j = 0; j < PAIRS; j++) begin
                outr[2*g + (j % 2)] = outr[2*g + (j % 2)] | (W'(csum[g][j]) << (2*j));
            end
        end
    end

    for (genvar o = 0; o < ROWS_OUT; o++) begin : g_out
        assign rows_o[o*W +: W] = outr[o];
    end

    // Arithmetic conservation across the level (R7, R1).
    logic [W-1:0] in_tot;
    logic [W-1:0] out_tot;
    always_comb begin
        in_tot  = '0;
        out_tot = '0;
        for (int r = 0; r < ROWS_IN; r++) begin
            in_tot = in_tot + rows_i[r*W +: W];
        end
        for (int o = 0; o < ROWS_OUT; o++) begin
            out_tot = out_tot + rows_o[o*W +: W];
        end
    end

    assert_level_conserves_R7 : assert property (
        @(posedge clk) disable iff (!rst_n) in_tot == out_tot
    );

endmodule

// File: rtl/red_cla.sv
// Two-operand adder from 4-bit lookahead groups with a group carry chain.
module red_cla #(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] s_o
);

    localparam int GROUPS = (W + 3) / 4;
    localparam int CW     = GROUPS * 4;

    logic [CW-1:0] ax;
    logic [CW-1:0] bx;
    logic [CW-1:0] s_full;
    logic          gc [GROUPS+1];

    assign ax    = CW'(a_i);
    assign bx    = CW'(b_i);
    assign gc[0] = 1'b0;

    for (genvar k = 0; k < GROUPS; k++) begin : g_grp
        logic [3:0] g;
        logic [3:0] p;
        logic [3:0] c;
        logic       grp_g;
        logic       grp_p;
        assign g = ax[4*k +: 4] & bx[4*k +: 4];
        assign p = ax[4*k +: 4] ^ bx[4*k +: 4];
        always_comb begin
            c[0]  = gc[k];
            c[1]  = g[0] | (p[0] & gc[k]);
            c[2]  = g[1] | (p[1] & g[0]) | (p[1] & p[0] & gc[k]);
            c[3]  = g[2] | (p[2] & g[1]) | (p[2] & p[1] & g[0])
                  | (p[2] & p[1] & p[0] & gc[k]);
            grp_g = g[3] | (p[3] & g[2]) | (p[3] & p[2] & g[1])
                  | (p[3] & p[2] & p[1] & g[0]);
            grp_p = &p;
        end
        assign gc[k+1]          = grp_g | (grp_p & gc[k]);
        assign s_full[4*k +: 4] = p ^ c;
    end

    assign s_o = s_full[W-1:0];

    logic [CW:0] add_ref;
    assign add_ref = {1'b0, ax} + {1'b0, bx};

    assert_cla_exact_R8 : assert property (
        @(posedge clk) disable iff (!rst_n) {gc[GROUPS], s_full} == add_ref
    );

endmodule

// File: rtl/red554_top.sv
module red554_top #(
    parameter int NUM_ROWS = 8,
    parameter int ROW_W    = 16,
    parameter int OUT_W    = ROW_W + $clog2(NUM_ROWS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_ROWS*ROW_W-1:0] i_rows,
    output logic [OUT_W-1:0]          o_sum
);
    import red554_pkg::*;

    localparam int IW = OUT_W + (OUT_W % 2);
    localparam int R1 = rows_after(NUM_ROWS);
    localparam int R2 = rows_after(R1);
    localparam int R3 = rows_after(R2);

    logic [NUM_ROWS*IW-1:0] stage0;
    logic [R1*IW-1:0]       stage1;
    logic [R2*IW-1:0]       stage2;
    logic [R3*IW-1:0]       stage3;
    logic [IW-1:0]          cla_s;

    for (genvar r = 0; r < NUM_ROWS; r++) begin : g_widen
        assign stage0[r*IW +: IW] = IW'(i_rows[r*ROW_W +: ROW_W]);
    end

    red_level #(.ROWS_IN(NUM_ROWS), .W(IW), .ROWS_OUT(R1)) u_lvl1 (
        .clk (clk), .rst_n (rst_n), .rows_i (stage0), .rows_o (stage1)
    );
    red_level #(.ROWS_IN(R1), .W(IW), .ROWS_OUT(R2)) u_lvl2 (
        .clk (clk), .rst_n (rst_n), .rows_i (stage1), .rows_o (stage2)
    );
    red_level #(.ROWS_IN(R2), .W(IW), .ROWS_OUT(R3)) u_lvl3 (
        .clk (clk), .rst_n (rst_n), .rows_i (stage2), .rows_o (stage3)
    );

    red_cla #(.W(IW)) u_cla (
        .clk   (clk),
        .rst_n (rst_n),
        .a_i   (stage3[IW-1:0]),
        .b_i   (stage3[2*IW-1:IW]),
        .s_o   (cla_s)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_sum <= '0;
        end else begin
            o_sum <= cla_s[OUT_W-1:0];
        end
    end

    // Plain arithmetic total, independent of the counter tree.
    logic [OUT_W-1:0] ref_total;
    always_comb begin
        ref_total = '0;
        for (int r = 0; r < NUM_ROWS; r++) begin
            ref_total = ref_total + OUT_W'(i_rows[r*ROW_W +: ROW_W]);
        end
    end

    assert_no_overflow_R2 : assert property (
        @(posedge clk) disable iff (!rst_n) (cla_s >> OUT_W) == '0
    );

    assert_one_cycle_sum_R3 : assert property (
        @(posedge clk) disable iff (!rst_n) $past(rst_n) |-> o_sum == $past(ref_total)
    );

    assert_reset_clear_R4 : assert property (
        @(posedge clk) !rst_n |-> o_sum == '0
    );

endmodule

// File: tb/sim_red554_top.sv
module sim_red554_top;
    localparam int NR = 8;
    localparam int RW = 16;
    localparam int OW = RW + $clog2(NR);

    logic              clk = 1'b0;
    logic              rst_n = 1'b1;
    logic [NR*RW-1:0]  rows = '0;
    logic [OW-1:0]     sum;

    int n_tests = 0;
    int n_fail  = 0;
    logic [OW-1:0] expq [$];

    always #10 clk = ~clk;

    red554_top #(.NUM_ROWS(NR), .ROW_W(RW)) u0 (
        .clk    (clk),
        .rst_n  (rst_n),
        .i_rows (rows),
        .o_sum  (sum)
    );

    function automatic logic [OW-1:0] ref_sum(input logic [NR*RW-1:0] v);
        longint t = 0;
        for (int r = 0; r < NR; r++) t += longint'(v[r*RW +: RW]);
        return t[OW-1:0];
    endfunction

    task automatic check(input string req, input logic [OW-1:0] act, input logic [OW-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive just after a falling edge; result due at the next rising edge,
    // compared at the falling edge after it.
    task automatic drive(input string req, input logic [NR*RW-1:0] v);
        rows = v;
        expq.push_back(ref_sum(v));
        @(negedge clk);
        check(req, sum, expq.pop_front());
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [NR*RW-1:0] v;
        #2 rst_n = 1'b0;
        @(negedge clk);
        check("R4 reset", sum, '0);
        @(negedge clk);
        check("R4 reset held", sum, '0);
        rst_n = 1'b1;

        drive("R2 zeros", '0);
        drive("R5 all ones", '1);
        check("R5 max value", sum, OW'(NR * 65535));

        for (int r = 0; r < NR; r++) begin
            v = '0;
            v[r*RW +: RW] = 16'hA5C3 ^ 16'(r * 16'h1111);
            drive("R6 single row", v);
            check("R6 passthrough", sum, OW'(16'hA5C3 ^ 16'(r * 16'h1111)));
        end

        // R1: load one counter's two columns with a set bits low, b set bits high.
        for (int j = 0; j < RW/2; j++) begin
            for (int a = 0; a <= 5; a++) begin
                for (int b = 0; b <= 5; b++) begin
                    v = '0;
                    for (int r = 0; r < 5; r++) begin
                        if (r < a) v[r*RW + 2*j]     = 1'b1;
                        if (r < b) v[r*RW + 2*j + 1] = 1'b1;
                    end
                    drive("R1 counter columns", v);
                end
            end
        end

        // R1 second group (rows 5..7, padded with zero rows)
        for (int j = 0; j < RW/2; j++) begin
            v = '0;
            for (int r = 5; r < NR; r++) v[r*RW + 2*j +: 2] = 2'b11;
            drive("R1 padded group", v);
        end

        // R8: carry through all lookahead groups
        v = '0;
        v[0 +: RW]  = '1;
        v[RW +: RW] = 16'd1;
        drive("R8 long carry", v);
        check("R8 carry value", sum, OW'(32'h10000));

        // R7 / R3: random back-to-back patterns
        for (int i = 0; i < 300; i++) begin
            for (int r = 0; r < NR; r++) v[r*RW +: RW] = 16'($urandom);
            drive("R3 R7 random stream", v);
        end

        // R4: asynchronous clear mid-run
        v = '1;
        drive("R2 before reset", v);
        #3 rst_n = 1'b0;
        #1 check("R4 async clear", sum, '0);
        @(negedge clk);
        check("R4 held low", sum, '0);
        rst_n = 1'b1;
        drive("R3 after reset", {NR{16'h0F0F}});

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule